// File: doc/BRIEF.md
# Cascaded Three-Bank Interrupt Controller

This block collects 96 interrupt sources into a single request line for a processor. Two 32-bit main cause banks take level inputs. A third 32-bit bank takes general-purpose pin inputs. It latches each rising edge on these pins and holds it until software clears it. Groups of eight masked pin-bank bits are folded into summary bits of the high main bank, so the pin bank sits one level below the main banks.

Software talks to the block through a word-addressed register port with one-cycle reads and writes. Each bank has a mask register. A read-only vector register returns the number of the winning source, or a spurious code when nothing qualifies. The vector logic walks a fixed path. The low bank is searched first. The high bank is searched next. If a summary bit wins the high bank, the search moves to the pin bank. The outcome is held in an enumerated path state: PATH_NONE (spurious), PATH_LO, PATH_HI or PATH_GPP.

The choice is made again every cycle from the current register state. There are no sequential transitions. Reading the vector while PATH_GPP is selected clears the winning pin-bank bit.

Top module: `casc_irq_ctrl`

## Requirements
- R1: Source numbers are 0–31 for the low main bank, 32–63 for the high main bank and 64–95 for pin-bank bits 0–31.
- R2: A low-bank bit qualifies only if its cause bit, its low-mask bit and the fixed low filter 0x3DFFFFFE are all set.
- R3: A high-bank bit qualifies only if its cause bit, its high-mask bit and the fixed high filter 0x0F000DB7 are all set.
- R4: Any qualified low-bank bit wins over every high-bank and pin-bank source.
- R5: Within a bank, the highest-numbered qualified bit wins.
- R6: A high-bank winner at index 24 or above selects the pin bank. The vector is then 64 plus the highest set bit of (pin cause AND pin mask). Any other high-bank winner gives its index plus 32.
- R7: With no qualified source, the vector reads 0xFFFFFFFE. It also reads 0xFFFFFFFE when a summary wins but no masked pin-bank bit is set.
- R8: A write to the pin cause register clears each bit written as 0 and keeps each bit written as 1. A vector read (reg_rd high, address 6) that returns a pin-bank source clears that one bit at the clock edge.
- R9: After reset the low mask, the pin mask and the pin cause are 0, and the high mask is 0x0F000000.
- R10: High-bank bits 24–27 read as the OR of (pin cause AND pin mask) over pin bits 0–7, 8–15, 16–23 and 24–31 in that order. The hi_src inputs at these positions have no effect.
- R11: Main cause registers take the level of their inputs at each clock edge. A pin cause bit is set by a 0-to-1 change of its input and stays set while the input stays high or falls.
- R12: cpu_irq is registered. It is high in the cycle after the register state would give a non-spurious vector.
- R13: Word addresses are: 0 low cause, 1 high cause, 2 low mask, 3 high mask, 4 pin cause, 5 pin mask, 6 vector, and 7 reads 0. Masks read back what was written. Writes to addresses 0, 1, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_src | input | 32 | Level sources for the low main bank |
| hi_src | input | 32 | Level sources for the high main bank (bits 24–27 unused) |
| gpp_src | input | 32 | Edge-latched general-purpose pin sources |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; needed for the vector auto-clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench uses the default parameters: eight pin bits per summary, summaries starting at high-bank bit 24, and the two fixed filters shown above. With these values, filtered-out bits at the top of the low bank and in the middle of the high bank can be driven and shown to be ignored. A summary win can be traced to a pin-bank vector and its auto-clear. A behavioural model follows every register and the request line on every clock. Directed reads also check each requirement against values worked out by hand.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

    localparam int unsigned BANK_W = 32;
    localparam int unsigned IDX_W  = $clog2(BANK_W);

    typedef logic [BANK_W-1:0] bank_t;

    localparam bank_t SPURIOUS_VEC = 32'hFFFF_FFFE;

    typedef enum logic [2:0] {
        ADR_LO_CAUSE  = 3'd0,
        ADR_HI_CAUSE  = 3'd1,
        ADR_LO_MASK   = 3'd2,
        ADR_HI_MASK   = 3'd3,
        ADR_GPP_CAUSE = 3'd4,
        ADR_GPP_MASK  = 3'd5,
        ADR_VECTOR    = 3'd6,
        ADR_NONE      = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        PATH_NONE,
        PATH_LO,
        PATH_HI,
        PATH_GPP
    } win_path_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // highest set bit wins: later iterations overwrite earlier ones
    function automatic pick_t top_bit(input bank_t v);
        pick_t p;
        p = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/casc_irq_gpp.sv
module casc_irq_gpp
    import casc_irq_pkg::*;
#(
    parameter int unsigned GRP_W = 8,
    localparam int unsigned NGRP = BANK_W / GRP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bank_t           src,
    input  logic            wr_cause,
    input  logic            wr_mask,
    input  bank_t           wdata,
    input  bank_t           auto_clr,
    output bank_t           cause,
    output bank_t           mask,
    output logic [NGRP-1:0] summary
);

    bank_t prev;
    bank_t rise;
    bank_t keep;

    assign rise = src & ~prev;
    assign keep = wr_cause ? wdata : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev  <= '0;
            cause <= '0;
            mask  <= '0;
        end else begin
            prev  <= src;
            cause <= (cause & keep & ~auto_clr) | rise;
            if (wr_mask) begin
                mask <= wdata;
            end
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_sum
        assign summary[g] = |(cause[g*GRP_W +: GRP_W] & mask[g*GRP_W +: GRP_W]);
    end

    // R8: bits written as zero are gone next cycle unless a fresh edge arrived
    a_r8_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> ((cause & ~$past(wdata) & ~$past(rise)) == '0));

    // R11: without a write or auto-clear, latched bits stay set
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cause && auto_clr == '0) |=> ((cause & $past(cause)) == $past(cause)));

endmodule

// File: rtl/casc_irq_main.sv
module casc_irq_main
    import casc_irq_pkg::*;
#(
    parameter int unsigned NGRP    = 4,
    parameter int unsigned SUM_LSB = 24,
    localparam bank_t SUM_FIELD    = bank_t'(((1 << NGRP) - 1) << SUM_LSB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bank_t           lo_src,
    input  bank_t           hi_src,
    input  logic [NGRP-1:0] summary,
    input  logic            wr_lo_mask,
    input  logic            wr_hi_mask,
    input  bank_t           wdata,
    output bank_t           lo_cause,
    output bank_t           hi_cause,
    output bank_t           lo_mask,
    output bank_t           hi_mask
);

    bank_t hi_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cause <= '0;
            hi_lvl   <= '0;
            lo_mask  <= '0;
            hi_mask  <= SUM_FIELD;
        end else begin
            lo_cause <= lo_src;
            hi_lvl   <= hi_src;
            if (wr_lo_mask) begin
                lo_mask <= wdata;
            end
            if (wr_hi_mask) begin
                hi_mask <= wdata;
            end
        end
    end

    assign hi_cause = (hi_lvl & ~SUM_FIELD) | (bank_t'(summary) << SUM_LSB);

endmodule

// File: rtl/casc_irq_resolve.sv
module casc_irq_resolve
    import casc_irq_pkg::*;
#(
    parameter bank_t       LO_FILTER = 32'h3DFF_FFFE,
    parameter bank_t       HI_FILTER = 32'h0F00_0DB7,
    parameter int unsigned SUM_LSB   = 24
) (
    input  logic  clk,
    input  logic  rst_n,
    input  bank_t lo_cause,
    input  bank_t hi_cause,
    input  bank_t lo_mask,
    input  bank_t hi_mask,
    input  bank_t gpp_cause,
    input  bank_t gpp_mask,
    output bank_t vector,
    output logic  pending,
    output bank_t gpp_win
);

    pick_t     lo_p;
    pick_t     hi_p;
    pick_t     gp_p;
    win_path_e path;

    // path selection: low bank, then high bank, then the cascade
    always_comb begin
        lo_p = top_bit(lo_cause & LO_FILTER & lo_mask);
        hi_p = top_bit(hi_cause & HI_FILTER & hi_mask);
        gp_p = top_bit(gpp_cause & gpp_mask);
        if (lo_p.hit) begin
            path = PATH_LO;
        end else if (hi_p.hit && int'(hi_p.idx) >= int'(SUM_LSB)) begin
            path = gp_p.hit ? PATH_GPP : PATH_NONE;
        end else if (hi_p.hit) begin
            path = PATH_HI;
        end else begin
            path = PATH_NONE;
        end
    end

    // outputs per path
    always_comb begin
        gpp_win = '0;
        unique case (path)
            PATH_LO:  vector = bank_t'(lo_p.idx);
            PATH_HI:  vector = bank_t'(hi_p.idx) + bank_t'(BANK_W);
            PATH_GPP: begin
                vector  = bank_t'(gp_p.idx) + bank_t'(2 * BANK_W);
                gpp_win = bank_t'(1) << gp_p.idx;
            end
            default:  vector = SPURIOUS_VEC;
        endcase
        pending = (path != PATH_NONE);
    end

    // R4: a qualified low bit always yields a low-bank number
    a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_cause & LO_FILTER & lo_mask) != '0) |-> (vector < bank_t'(BANK_W)));

    // R6: a cascade hit reports a number in the pin-bank range
    a_r6_gpp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (gpp_win != '0) |-> (vector >= bank_t'(2 * BANK_W) && vector < bank_t'(3 * BANK_W)));

    // R7: the spurious code appears only when the low bank has nothing qualified
    a_r7_spur_code: assert property (@(posedge clk) disable iff (!rst_n)
        (vector == SPURIOUS_VEC) |-> ((lo_cause & LO_FILTER & lo_mask) == '0 && !pending));

    // R8: auto-clear target is a single masked, set pin bit
    a_r8_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gpp_win) && ((gpp_win & ~(gpp_cause & gpp_mask)) == '0));

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import casc_irq_pkg::*;
#(
    parameter int unsigned GRP_W     = 8,
    parameter int unsigned SUM_LSB   = 24,
    parameter bank_t       LO_FILTER = 32'h3DFF_FFFE,
    parameter bank_t       HI_FILTER = 32'h0F00_0DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lo_src,
    input  logic [31:0] hi_src,
    input  logic [31:0] gpp_src,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cpu_irq
);

    localparam int unsigned NGRP = BANK_W / GRP_W;

    reg_addr_e       addr_e;
    bank_t           lo_cause, hi_cause, lo_mask, hi_mask;
    bank_t           gpp_cause, gpp_mask, gpp_win, auto_clr, vector;
    logic [NGRP-1:0] summary;
    logic            pending;

    assign addr_e   = reg_addr_e'(reg_addr);
    assign auto_clr = (reg_rd && addr_e == ADR_VECTOR) ? gpp_win : '0;

    casc_irq_gpp #(.GRP_W(GRP_W)) u_gpp (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (gpp_src),
        .wr_cause (reg_wr && addr_e == ADR_GPP_CAUSE),
        .wr_mask  (reg_wr && addr_e == ADR_GPP_MASK),
        .wdata    (reg_wdata),
        .auto_clr (auto_clr),
        .cause    (gpp_cause),
        .mask     (gpp_mask),
        .summary  (summary)
    );

    casc_irq_main #(.NGRP(NGRP), .SUM_LSB(SUM_LSB)) u_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_src     (lo_src),
        .hi_src     (hi_src),
        .summary    (summary),
        .wr_lo_mask (reg_wr && addr_e == ADR_LO_MASK),
        .wr_hi_mask (reg_wr && addr_e == ADR_HI_MASK),
        .wdata      (reg_wdata),
        .lo_cause   (lo_cause),
        .hi_cause   (hi_cause),
        .lo_mask    (lo_mask),
        .hi_mask    (hi_mask)
    );

    casc_irq_resolve #(
        .LO_FILTER (LO_FILTER),
        .HI_FILTER (HI_FILTER),
        .SUM_LSB   (SUM_LSB)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_cause  (lo_cause),
        .hi_cause  (hi_cause),
        .lo_mask   (lo_mask),
        .hi_mask   (hi_mask),
        .gpp_cause (gpp_cause),
        .gpp_mask  (gpp_mask),
        .vector    (vector),
        .pending   (pending),
        .gpp_win   (gpp_win)
    );

    always_comb begin
        unique case (addr_e)
            ADR_LO_CAUSE:  reg_rdata = lo_cause;
            ADR_HI_CAUSE:  reg_rdata = hi_cause;
            ADR_LO_MASK:   reg_rdata = lo_mask;
            ADR_HI_MASK:   reg_rdata = hi_mask;
            ADR_GPP_CAUSE: reg_rdata = gpp_cause;
            ADR_GPP_MASK:  reg_rdata = gpp_mask;
            ADR_VECTOR:    reg_rdata = vector;
            default:       reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_irq <= 1'b0;
        end else begin
            cpu_irq <= pending;
        end
    end

    // R12: no request can be raised while the low mask and high mask are both empty
    a_r12_quiet_masks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lo_mask) == '0 && $past(hi_mask) == '0) |-> !cpu_irq);

endmodule

// File: tb/casc_irq_ctrl_tb.sv
module casc_irq_ctrl_tb;

    localparam time TCK = 8ns;
    localparam logic [31:0] SPUR = 32'hFFFF_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lo_src = '0, hi_src = '0, gpp_src = '0, reg_wdata = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    wire  [31:0] reg_rdata;
    wire         cpu_irq;
    int          n_chk = 0, n_fail = 0;
    logic        done = 1'b0;

    always #(TCK/2) clk = ~clk;

    casc_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lo_src(lo_src), .hi_src(hi_src),
        .gpp_src(gpp_src), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq)
    );

    // behavioural reference state
    logic [31:0] m_lo = '0, m_hi = '0, m_gpp = '0, m_prev = '0;
    logic [31:0] m_lom = '0, m_him = 32'h0F00_0000, m_gm = '0;
    logic        m_irq = 1'b0;

    function automatic logic [31:0] m_hi_view();
        logic [31:0] v;
        v = m_hi;
        for (int g = 0; g < 4; g++) begin
            v[24+g] = 1'b0;
            for (int b = 0; b < 8; b++)
                if (m_gpp[g*8+b] && m_gm[g*8+b]) v[24+g] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] m_vector();
        logic [31:0] q;
        int w;
        q = m_lo & 32'h3DFF_FFFE & m_lom;
        for (int i = 31; i >= 0; i--) if (q[i]) return 32'(i);
        q = m_hi_view() & 32'h0F00_0DB7 & m_him;
        w = -1;
        for (int i = 31; i >= 0; i--) if (q[i] && w < 0) w = i;
        if (w < 0) return SPUR;
        if (w < 24) return 32'(w + 32);
        q = m_gpp & m_gm;
        for (int i = 31; i >= 0; i--) if (q[i]) return 32'(i + 64);
        return SPUR;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_lo;
            3'd1: return m_hi_view();
            3'd2: return m_lom;
            3'd3: return m_him;
            3'd4: return m_gpp;
            3'd5: return m_gm;
            3'd6: return m_vector();
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin : mdl
        logic [31:0] v, nc;
        if (!rst_n) begin
            m_lo = '0; m_hi = '0; m_gpp = '0; m_prev = '0;
            m_lom = '0; m_him = 32'h0F00_0000; m_gm = '0; m_irq = 1'b0;
        end else begin
            v  = m_vector();
            nc = m_gpp;
            if (reg_wr && reg_addr == 3'd4) nc = nc & reg_wdata;
            if (reg_rd && reg_addr == 3'd6 && v != SPUR && v >= 64) nc[v[4:0]] = 1'b0;
            nc     = nc | (gpp_src & ~m_prev);
            m_irq  = (v != SPUR);
            m_prev = gpp_src;
            m_gpp  = nc;
            m_lo   = lo_src;
            m_hi   = hi_src;
            if (reg_wr && reg_addr == 3'd2) m_lom = reg_wdata;
            if (reg_wr && reg_addr == 3'd3) m_him = reg_wdata;
            if (reg_wr && reg_addr == 3'd5) m_gm  = reg_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // R12: request line against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) check("R12 cpu_irq vs model", {31'd0, cpu_irq}, {31'd0, m_irq});
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        check(tag, reg_rdata, exp);
        check({tag, " (R13 model)"}, reg_rdata, m_read(a));
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R12 cpu_irq after reset", {31'd0, cpu_irq}, 32'd0);
        rd(3'd2, 32'h0, "R9 low mask reset");
        rd(3'd3, 32'h0F00_0000, "R9 high mask reset");
        rd(3'd5, 32'h0, "R9 pin mask reset");
        rd(3'd4, 32'h0, "R9 pin cause reset");
        rd(3'd6, SPUR, "R7 nothing pending");

        wr(3'd2, 32'hFFFF_FFFF);
        @(negedge clk); lo_src = 32'h4200_0001;
        rd(3'd0, 32'h4200_0001, "R11 low level sampled");
        rd(3'd6, SPUR, "R2 filtered low bits ignored");
        @(negedge clk); lo_src = 32'h6200_0021;
        rd(3'd6, 32'd29, "R5 highest low bit");
        wr(3'd2, 32'h0000_00FF);
        rd(3'd6, 32'd5, "R2 low mask applied");
        rd(3'd2, 32'h0000_00FF, "R13 mask readback");

        @(negedge clk); lo_src = '0; hi_src = 32'h1100_0409;
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd1, 32'h1000_0409, "R10 external summary position ignored");
        rd(3'd6, 32'd42, "R3 high filter, R6 offset 32");
        wr(3'd3, 32'h0F00_0001);
        rd(3'd6, 32'd32, "R6 high index 0 gives 32");
        @(negedge clk); lo_src = 32'h2;
        rd(3'd6, 32'd1, "R4 low bank first");
        @(negedge clk); lo_src = '0;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h1234_5678);
        rd(3'd0, 32'h0, "R13 cause not writable");
        rd(3'd7, 32'h0, "R13 unused address");
        rd(3'd6, 32'd32, "R13 vector not writable");

        wr(3'd5, 32'h0000_8101);
        @(negedge clk); gpp_src = 32'h0010_0101;
        @(negedge clk); gpp_src = '0;
        rd(3'd4, 32'h0010_0101, "R11 pin edge latched and held");
        rd(3'd1, 32'h1300_0409, "R10 summaries per group");
        rd(3'd6, 32'd72, "R6 cascade to pin bank");
        rd(3'd4, 32'h0010_0001, "R8 auto-clear of winner");
        rd(3'd6, 32'd64, "R1 pin bit 0 is 64");
        rd(3'd4, 32'h0010_0000, "R8 second auto-clear");
        rd(3'd6, 32'd32, "R6 back to high bank");

        @(negedge clk); gpp_src = 32'h8;
        rd(3'd4, 32'h0010_0008, "R11 rise sets bit");
        wr(3'd4, 32'hFFFF_FFF7);
        rd(3'd4, 32'h0010_0000, "R8 zero clears, held level no relatch");
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 32'h0010_0000, "R8 ones keep");
        wr(3'd4, 32'h0);
        rd(3'd4, 32'h0, "R8 all cleared");

        @(negedge clk); hi_src = '0; gpp_src = '0;
        repeat (3) @(negedge clk);
        check("R12 idle low", {31'd0, cpu_irq}, 32'd0);
        lo_src = 32'h20;
        @(negedge clk);
        check("R12 not yet raised", {31'd0, cpu_irq}, 32'd0);
        @(negedge clk);
        check("R12 raised one cycle after cause", {31'd0, cpu_irq}, 32'd1);
        lo_src = '0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule